// File: doc/BRIEF.md
# I2C Slave Address Matcher

This block watches the address phase of each I2C transaction and decides whether the local slave is being addressed. A bit-level front end, which is not part of this block, feeds it whole received bytes together with a byte strobe and a marker for START or repeated START. The block compares the first byte, or the first two bytes in 10-bit mode, against a programmed 10-bit own address. It also accepts the general-call address or the start byte when that option is enabled.

When a match is found, a sticky match flag is raised. A side flag tells whether the hit came from the all-zero general-call/start-byte address or from the own address, and a direction output gives the read/write bit of the address byte. Software clears the match flag by reading status, which reaches the block as a one-cycle read strobe. All outputs are registered and change on the clock edge after the byte that decides them.

Top module: `i2c_addr_match`

## Requirements
- R1: After synchronous reset, `match_o`, `gcall_o` and `dir_o` are 0, and no byte sets the match until a START marker has been seen.
- R2: In 7-bit mode (`mode_i` = 2'b00), when bits [7:1] of the first byte after a START equal own-address bits [6:0], `match_o` becomes 1 on the next clock edge with `gcall_o` = 0 and `dir_o` = byte bit 0 (1 = read).
- R3: In 10-bit mode (`mode_i` = 2'b01), a first byte equal to {5'b11110, own[9:8], rw} followed by a second byte equal to own[7:0] sets `match_o` on the edge after the second byte, with `gcall_o` = 0 and `dir_o` = rw taken from the first byte. The first byte alone never sets the match.
- R4: With `gc_en_i` = 1 in either valid mode, a first byte of 8'h00 (general call) or 8'h01 (start byte) sets `match_o` with `gcall_o` = 1 and `dir_o` = byte bit 0. With `gc_en_i` = 0 these bytes do not match.
- R5: A mismatch on either address byte leaves the slave unselected: later bytes set no match until the next START.
- R6: Bytes after a completed address phase are data and never set the match, even when they equal an address pattern.
- R7: A START marker resets the matcher to expect a first address byte. If a byte strobe arrives in the same cycle as a START, that byte is discarded.
- R8: A `mode_i` value of 2'b10 or 2'b11 disables all matching, including the general call.
- R9: A status-read strobe `stat_rd_i` clears `match_o` on the next edge. If a new hit happens in the same cycle as the read, `match_o` stays 1.
- R10: `gcall_o` and `dir_o` hold their values through status reads and non-matching traffic, and change only on a new hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | START or repeated START detected (one-cycle pulse) |
| byte_valid_i | input | 1 | `byte_i` holds a newly received byte |
| byte_i | input | 8 | Received byte, MSB first on the wire |
| own_addr_i | input | 10 | Own slave address |
| mode_i | input | 2 | 00 = 7-bit, 01 = 10-bit, others = matching off |
| gc_en_i | input | 1 | Accept general call / start byte |
| stat_rd_i | input | 1 | Status-read strobe, clears the match flag |
| match_o | output | 1 | Slave address matched (sticky) |
| gcall_o | output | 1 | Last hit was the general-call/start-byte address |
| dir_o | output | 1 | R/W bit of the last hit address (1 = read) |

## Verification
Two events can land on the same clock edge: a status read that clears the match flag, and a new address hit that sets it. The bench provokes this by pulsing `stat_rd_i` in the same cycle as a matching byte strobe, and expects `match_o` to stay 1 with the new `gcall_o` and `dir_o`. It also collides a START marker with a byte strobe, and expects the byte to be discarded and the matcher to wait for a fresh first byte. A behavioural reference model compares all three outputs on every cycle.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_FIRST  = 2'd1,
    PH_SECOND = 2'd2,
    PH_DONE   = 2'd3
  } phase_t;

  localparam logic [1:0] MODE_7B  = 2'b00;
  localparam logic [1:0] MODE_10B = 2'b01;
  localparam logic [4:0] TEN_BIT_PREFIX = 5'b11110;
endpackage

// File: rtl/i2c_am_decode.sv
module i2c_am_decode
  import i2c_am_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int BYTE_W = 8
) (
  input  phase_t              phase,
  input  logic [BYTE_W-1:0]   rx_byte,
  input  logic [ADDR_W-1:0]   own_addr,
  input  logic [1:0]          mode,
  input  logic                gc_en,
  input  logic                pend_dir,
  output logic                hit,
  output logic                hit_gc,
  output logic                hit_dir,
  output logic                to_second
);
  localparam int HI_W = ADDR_W - BYTE_W;
  localparam int SA_W = BYTE_W - 1;

  logic mode_ok;
  logic gc_pat, own7_pat, ten_hdr_pat, ten_lo_pat;

  always_comb begin
    mode_ok     = (mode == MODE_7B) || (mode == MODE_10B);
    gc_pat      = (rx_byte[BYTE_W-1:1] == '0);
    own7_pat    = (rx_byte[BYTE_W-1:1] == own_addr[SA_W-1:0]);
    ten_hdr_pat = (rx_byte[BYTE_W-1 -: 5] == TEN_BIT_PREFIX) &&
                  (rx_byte[HI_W:1] == own_addr[ADDR_W-1 -: HI_W]);
    ten_lo_pat  = (rx_byte == own_addr[BYTE_W-1:0]);

    hit       = 1'b0;
    hit_gc    = 1'b0;
    hit_dir   = 1'b0;
    to_second = 1'b0;
    if (phase == PH_FIRST && mode_ok) begin
      if (gc_en && gc_pat) begin
        hit     = 1'b1;
        hit_gc  = 1'b1;
        hit_dir = rx_byte[0];
      end else if (mode == MODE_7B && own7_pat) begin
        hit     = 1'b1;
        hit_dir = rx_byte[0];
      end else if (mode == MODE_10B && ten_hdr_pat) begin
        to_second = 1'b1;
      end
    end else if (phase == PH_SECOND && mode == MODE_10B && ten_lo_pat) begin
      hit     = 1'b1;
      hit_dir = pend_dir;
    end
  end
endmodule

// File: rtl/i2c_am_flags.sv
module i2c_am_flags (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic set_gc_i,
  input  logic set_dir_i,
  input  logic clr_i,
  output logic match_o,
  output logic gcall_o,
  output logic dir_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      match_o <= 1'b0;
      gcall_o <= 1'b0;
      dir_o   <= 1'b0;
    end else if (set_i) begin
      match_o <= 1'b1;
      gcall_o <= set_gc_i;
      dir_o   <= set_dir_i;
    end else if (clr_i) begin
      match_o <= 1'b0;
    end
  end

  // R9
  read_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> !match_o);
  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    set_i |=> match_o);
  // R10
  side_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !set_i |=> ($stable(gcall_o) && $stable(dir_o)));
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
  import i2c_am_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              byte_valid_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic [1:0]        mode_i,
  input  logic              gc_en_i,
  input  logic              stat_rd_i,
  output logic              match_o,
  output logic              gcall_o,
  output logic              dir_o
);
  phase_t phase;
  logic   pend_dir;
  logic   hit, hit_gc, hit_dir, to_second;
  logic   take;
  logic   set;

  assign take = byte_valid_i && !start_i;
  assign set  = take && hit;

  i2c_am_decode #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_dec (
    .phase     (phase),
    .rx_byte   (byte_i),
    .own_addr  (own_addr_i),
    .mode      (mode_i),
    .gc_en     (gc_en_i),
    .pend_dir  (pend_dir),
    .hit       (hit),
    .hit_gc    (hit_gc),
    .hit_dir   (hit_dir),
    .to_second (to_second)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      pend_dir <= 1'b0;
    end else if (start_i) begin
      phase <= PH_FIRST;
    end else if (byte_valid_i) begin
      case (phase)
        PH_FIRST: begin
          phase    <= to_second ? PH_SECOND : PH_DONE;
          pend_dir <= byte_i[0];
        end
        PH_SECOND: phase <= PH_DONE;
        default:   phase <= phase;
      endcase
    end
  end

  i2c_am_flags u_flags (
    .clk       (clk),
    .rst       (rst),
    .set_i     (set),
    .set_gc_i  (hit_gc),
    .set_dir_i (hit_dir),
    .clr_i     (stat_rd_i),
    .match_o   (match_o),
    .gcall_o   (gcall_o),
    .dir_o     (dir_o)
  );

  // R7
  start_rearm_chk: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (phase == PH_FIRST));
  // R8
  mode_off_chk: assert property (@(posedge clk) disable iff (rst)
    mode_i[1] |-> !hit);
  // R5
  done_no_hit_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_DONE || phase == PH_IDLE) |-> !hit);
  // R3
  ten_second_chk: assert property (@(posedge clk) disable iff (rst)
    (take && to_second) |=> (phase == PH_SECOND));
endmodule

// File: tb/i2c_addr_match_bench.sv
module i2c_addr_match_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0, byte_valid_i = 1'b0, gc_en_i = 1'b0, stat_rd_i = 1'b0;
  logic [7:0] byte_i = '0;
  logic [9:0] own_addr_i = 10'h2A5;
  logic [1:0] mode_i = 2'b00;
  logic match_o, gcall_o, dir_o;

  int total = 0, bad = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  i2c_addr_match u_i2c_addr_match (
    .clk(clk), .rst(rst), .start_i(start_i), .byte_valid_i(byte_valid_i),
    .byte_i(byte_i), .own_addr_i(own_addr_i), .mode_i(mode_i), .gc_en_i(gc_en_i),
    .stat_rd_i(stat_rd_i), .match_o(match_o), .gcall_o(gcall_o), .dir_o(dir_o)
  );

  // reference model: ph 0 idle, 1 first byte, 2 second byte, 3 address phase over
  int m_ph = 0;
  logic m_pend = 0, m_match = 0, m_gc = 0, m_dir = 0;

  always @(posedge clk) begin
    logic h, hg, hd;
    int nph;
    h = 0; hg = 0; hd = 0; nph = m_ph;
    if (rst) begin
      m_ph = 0; m_pend = 0; m_match = 0; m_gc = 0; m_dir = 0;
    end else begin
      if (start_i) nph = 1;
      else if (byte_valid_i) begin
        if (m_ph == 1) begin
          nph = 3;
          m_pend = byte_i[0];
          if (mode_i < 2 && gc_en_i && byte_i[7:1] == 0) begin h = 1; hg = 1; hd = byte_i[0]; end
          else if (mode_i == 0 && byte_i[7:1] == own_addr_i[6:0]) begin h = 1; hd = byte_i[0]; end
          else if (mode_i == 1 && byte_i[7:3] == 5'b11110 && byte_i[2:1] == own_addr_i[9:8]) nph = 2;
        end else if (m_ph == 2) begin
          nph = 3;
          if (mode_i == 1 && byte_i == own_addr_i[7:0]) begin h = 1; hd = m_pend; end
        end
      end
      m_ph = nph;
      if (h) begin m_match = 1; m_gc = hg; m_dir = hd; end
      else if (stat_rd_i) m_match = 0;
    end
  end

  task automatic check(string req, logic [2:0] act, logic [2:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: {match,gcall,dir} actual=%b expected=%b", req, act, exp);
    end
  endtask

  always @(negedge clk)
    if (!rst) check(cur_req, {match_o, gcall_o, dir_o}, {m_match, m_gc, m_dir});

  task automatic do_start(); @(negedge clk); start_i = 1; @(negedge clk); start_i = 0; endtask
  task automatic send(logic [7:0] b); @(negedge clk); byte_i = b; byte_valid_i = 1; @(negedge clk); byte_valid_i = 0; endtask
  task automatic rd(); @(negedge clk); stat_rd_i = 1; @(negedge clk); stat_rd_i = 0; endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1", {match_o, gcall_o, dir_o}, 3'b000);
    send(8'h4B);
    check("R1", {match_o, gcall_o, dir_o}, 3'b000);

    cur_req = "R2";
    do_start(); send(8'h4B);
    check("R2", {match_o, gcall_o, dir_o}, 3'b101);
    cur_req = "R10"; rd();
    check("R9", {match_o, gcall_o, dir_o}, 3'b001);
    send(8'h00);
    check("R10", {match_o, gcall_o, dir_o}, 3'b001);
    cur_req = "R6"; send(8'h4A); send(8'h4B);
    check("R6", {match_o, gcall_o, dir_o}, 3'b001);

    cur_req = "R5"; do_start(); send(8'h4C); send(8'h4A);
    check("R5", match_o, 1'b0);

    cur_req = "R4"; gc_en_i = 0; do_start(); send(8'h00);
    check("R4", match_o, 1'b0);
    gc_en_i = 1; do_start(); send(8'h00);
    check("R4", {match_o, gcall_o, dir_o}, 3'b110);
    rd(); do_start(); send(8'h01);
    check("R4", {match_o, gcall_o, dir_o}, 3'b111);
    rd();

    cur_req = "R3"; mode_i = 2'b01; do_start(); send(8'hF5);
    check("R3", match_o, 1'b0);
    send(8'hA5);
    check("R3", {match_o, gcall_o, dir_o}, 3'b101);
    rd(); do_start(); send(8'hF4); send(8'hA5);
    check("R3", {match_o, gcall_o, dir_o}, 3'b100);
    rd();
    cur_req = "R5"; do_start(); send(8'hF4); send(8'hA4); send(8'hA5);
    check("R5", match_o, 1'b0);
    do_start(); send(8'hF2); send(8'hA5);
    check("R5", match_o, 1'b0);
    cur_req = "R4"; do_start(); send(8'h00);
    check("R4", {match_o, gcall_o, dir_o}, 3'b110);
    rd();

    cur_req = "R7"; do_start(); send(8'hF5);
    @(negedge clk); start_i = 1; byte_valid_i = 1; byte_i = 8'hA5;
    @(negedge clk); start_i = 0; byte_valid_i = 0;
    check("R7", match_o, 1'b0);
    send(8'hF5); send(8'hA5);
    check("R7", {match_o, gcall_o, dir_o}, 3'b101);
    rd();

    cur_req = "R8";
    for (int m = 2; m < 4; m++) begin
      mode_i = m[1:0];
      do_start(); send(8'h00); do_start(); send(8'h4B);
      check("R8", match_o, 1'b0);
    end

    cur_req = "R9"; mode_i = 2'b00; do_start(); send(8'h4A);
    do_start();
    @(negedge clk); byte_i = 8'h01; byte_valid_i = 1; stat_rd_i = 1;
    @(negedge clk); byte_valid_i = 0; stat_rd_i = 0;
    check("R9", {match_o, gcall_o, dir_o}, 3'b111);
    rd();
    check("R9", match_o, 1'b0);

    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule